// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a write-back, write-allocate data cache. Its main array is direct-mapped. Beside it sits a small fully associative buffer that holds lines recently pushed out of the main array. Every lookup compares the request against the indexed main line and against every buffer entry in the same cycle. A hit in the main array completes at once. A hit in the buffer costs one extra cycle, in which the buffered line and the line in the indexed main slot trade places. When both structures miss, the line is fetched through a memory port. The valid main line that the fill displaces is pushed into the buffer.

The CPU side is a single request port with a ready signal and a registered response carrying a hit flag and read data. The memory side has two channels. The line-read channel holds its request until data is returned. The line-write channel holds its request until it is acknowledged, and it is used only when a dirty buffered line must make room. Lines carry valid and dirty state wherever they live, and that state moves with them.

Top module: `dm_victim_cache`

## Requirements
- R1: After reset every line in both structures is invalid, `req_ready` is 1, `resp_valid` is 0 and neither memory request is raised. A line that was cached before reset misses afterwards.
- R2: A request that hits the main array gives `resp_valid`=1 with `resp_hit`=1 in the cycle after the accepting edge. For reads, `resp_rdata` holds the addressed word, and `req_ready` stays 1.
- R3: A request that hits a buffer entry gives `resp_valid`=1 with `resp_hit`=1 two cycles after the accepting edge. Afterwards that line hits in the main array, and the line that held its main slot hits in the buffer.
- R4: A request that misses both structures raises `mem_rd_req` with line address `req_addr[ADDR_W-1:OFF_W]`. `req_ready` is 0 until the fill returns, and the response has `resp_hit`=0 with the word taken from the filled line.
- R5: The valid main line that a fill displaces goes into the buffer slots in round-robin order 0,1,2,3,0,… The previous occupant of the chosen slot leaves the cache.
- R6: If that previous occupant is valid and dirty, it is written to memory with its own line address and data before the fill is requested. A clean occupant is dropped without a memory write.
- R7: Writes update only the addressed word: bits `[off*WORD_W +: WORD_W]` of the line, where off = `req_addr[OFF_W-1:0]`. A write hit causes no memory traffic. A write miss fills the line first and then merges the word.
- R8: The dirty state of a line travels with it between the main array and the buffer. Written data survives swaps and reaches memory only on eviction from the buffer.
- R9: `mem_rd_req` and `mem_wr_req` are never high together. Each request holds its address, and for writes its data, stable until `mem_rd_valid` or `mem_wr_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address {tag, index, offset} |
| req_wdata | input | WORD_W | Write data |
| req_ready | output | 1 | Request accepted on this edge when valid |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Completion needed no memory fill |
| resp_rdata | output | WORD_W | Read data |
| mem_rd_req | output | 1 | Line fill request |
| mem_rd_addr | output | ADDR_W-OFF_W | Line address to fill |
| mem_rd_valid | input | 1 | Fill data present |
| mem_rd_data | input | (2**OFF_W)*WORD_W | Fill line |
| mem_wr_req | output | 1 | Line write-back request |
| mem_wr_addr | output | ADDR_W-OFF_W | Line address to write |
| mem_wr_data | output | (2**OFF_W)*WORD_W | Line to write |
| mem_wr_ack | input | 1 | Write-back accepted |

## Verification
The response arrives a fixed number of cycles after the accepting edge: one for a main hit, two for a buffer hit. For a miss it comes in the cycle after the memory returns the line, and any write-back adds its own cycles before that. The bench drives inputs and samples outputs on falling edges. After each accepting rising edge it counts falling edges until `resp_valid` shows, and compares that count exactly with 1 or 2 for hits and with "more than 2" for misses. `req_ready` is checked at the first falling edge after acceptance, and the write-back channel is checked through counters the bench memory keeps.

// File: rtl/dm_victim_cache.sv
module dm_victim_cache #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32,
  parameter int OFF_W  = 1,
  parameter int IDX_W  = 3,
  parameter int VICT_N = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic                              req_write,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [WORD_W-1:0]                 req_wdata,
  output logic                              req_ready,
  output logic                              resp_valid,
  output logic                              resp_hit,
  output logic [WORD_W-1:0]                 resp_rdata,
  output logic                              mem_rd_req,
  output logic [ADDR_W-OFF_W-1:0]           mem_rd_addr,
  input  logic                              mem_rd_valid,
  input  logic [(1<<OFF_W)*WORD_W-1:0]      mem_rd_data,
  output logic                              mem_wr_req,
  output logic [ADDR_W-OFF_W-1:0]           mem_wr_addr,
  output logic [(1<<OFF_W)*WORD_W-1:0]      mem_wr_data,
  input  logic                              mem_wr_ack
);
  localparam int LINE_W = (1 << OFF_W) * WORD_W;
  localparam int SETS   = 1 << IDX_W;
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int TAG_W  = LA_W - IDX_W;
  localparam int VP_W   = $clog2(VICT_N);

  typedef enum logic [1:0] {S_IDLE, S_SWAP, S_WB, S_FILL} st_t;
  st_t state;

  logic [SETS-1:0]   m_v, m_d;
  logic [TAG_W-1:0]  m_tag  [SETS];
  logic [LINE_W-1:0] m_data [SETS];

  logic [VICT_N-1:0] v_v, v_d;
  logic [LA_W-1:0]   v_la   [VICT_N];
  logic [LINE_W-1:0] v_data [VICT_N];
  logic [VP_W-1:0]   v_ptr;

  logic              q_write;
  logic [ADDR_W-1:0] q_addr;
  logic [WORD_W-1:0] q_wdata;
  logic [VP_W-1:0]   q_slot;

  function automatic logic [WORD_W-1:0] get_word(input logic [LINE_W-1:0] l,
                                                 input logic [OFF_W-1:0] o);
    return l[o*WORD_W +: WORD_W];
  endfunction

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] l,
                                                 input logic [OFF_W-1:0] o,
                                                 input logic [WORD_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = l;
    r[o*WORD_W +: WORD_W] = w;
    return r;
  endfunction

  wire [OFF_W-1:0] r_off = req_addr[OFF_W-1:0];
  wire [IDX_W-1:0] r_idx = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] r_tag = req_addr[ADDR_W-1 -: TAG_W];
  wire [LA_W-1:0]  r_la  = req_addr[ADDR_W-1:OFF_W];

  wire [OFF_W-1:0] q_off = q_addr[OFF_W-1:0];
  wire [IDX_W-1:0] q_idx = q_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] q_tag = q_addr[ADDR_W-1 -: TAG_W];

  wire main_hit = m_v[r_idx] && (m_tag[r_idx] == r_tag);

  logic [VICT_N-1:0] vhit;
  for (genvar i = 0; i < VICT_N; i++) begin : g_cmp
    assign vhit[i] = v_v[i] && (v_la[i] == r_la);
  end

  logic [VP_W-1:0] vsel;
  always_comb begin
    vsel = '0;
    for (int i = VICT_N - 1; i >= 0; i--)
      if (vhit[i]) vsel = VP_W'(i);
  end

  wire need_wb = m_v[r_idx] && v_v[v_ptr] && v_d[v_ptr];

  assign req_ready   = (state == S_IDLE);
  assign mem_rd_req  = (state == S_FILL);
  assign mem_rd_addr = q_addr[ADDR_W-1:OFF_W];
  assign mem_wr_req  = (state == S_WB);
  assign mem_wr_addr = v_la[v_ptr];
  assign mem_wr_data = v_data[v_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      m_v        <= '0;
      m_d        <= '0;
      v_v        <= '0;
      v_d        <= '0;
      v_ptr      <= '0;
      q_write    <= 1'b0;
      q_addr     <= '0;
      q_wdata    <= '0;
      q_slot     <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          if (main_hit) begin
            if (req_write) begin
              m_data[r_idx] <= put_word(m_data[r_idx], r_off, req_wdata);
              m_d[r_idx]    <= 1'b1;
            end
            resp_rdata <= get_word(m_data[r_idx], r_off);
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
          end else begin
            q_write <= req_write;
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
            q_slot  <= vsel;
            if (|vhit)        state <= S_SWAP;
            else if (need_wb) state <= S_WB;
            else              state <= S_FILL;
          end
        end
        S_SWAP: begin
          m_tag[q_idx]   <= v_la[q_slot][LA_W-1 -: TAG_W];
          m_data[q_idx]  <= q_write ? put_word(v_data[q_slot], q_off, q_wdata)
                                    : v_data[q_slot];
          m_v[q_idx]     <= 1'b1;
          m_d[q_idx]     <= v_d[q_slot] | q_write;
          v_la[q_slot]   <= {m_tag[q_idx], q_idx};
          v_data[q_slot] <= m_data[q_idx];
          v_v[q_slot]    <= m_v[q_idx];
          v_d[q_slot]    <= m_d[q_idx];
          resp_rdata     <= get_word(v_data[q_slot], q_off);
          resp_valid     <= 1'b1;
          resp_hit       <= 1'b1;
          state          <= S_IDLE;
        end
        S_WB: if (mem_wr_ack) begin
          v_v[v_ptr] <= 1'b0;
          v_d[v_ptr] <= 1'b0;
          state      <= S_FILL;
        end
        S_FILL: if (mem_rd_valid) begin
          if (m_v[q_idx]) begin
            v_la[v_ptr]   <= {m_tag[q_idx], q_idx};
            v_data[v_ptr] <= m_data[q_idx];
            v_v[v_ptr]    <= 1'b1;
            v_d[v_ptr]    <= m_d[q_idx];
            v_ptr         <= v_ptr + VP_W'(1);
          end
          m_tag[q_idx]  <= q_tag;
          m_data[q_idx] <= q_write ? put_word(mem_rd_data, q_off, q_wdata) : mem_rd_data;
          m_v[q_idx]    <= 1'b1;
          m_d[q_idx]    <= q_write;
          resp_rdata    <= get_word(mem_rd_data, q_off);
          resp_valid    <= 1'b1;
          resp_hit      <= 1'b0;
          state         <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dm_victim_cache_chk.sv
module dm_victim_cache_chk #(
  parameter int LA_W   = 11,
  parameter int LINE_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              mem_rd_req,
  input logic              mem_rd_valid,
  input logic [LA_W-1:0]   mem_rd_addr,
  input logic              mem_wr_req,
  input logic              mem_wr_ack,
  input logic [LA_W-1:0]   mem_wr_addr,
  input logic [LINE_W-1:0] mem_wr_data
);
  assert_one_mem_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && !mem_wr_ack |=> mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data));

  assert_wb_then_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && mem_wr_ack |=> mem_rd_req);

  assert_busy_in_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !req_ready);

  assert_miss_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_hit |-> $past(mem_rd_req && mem_rd_valid));

  assert_resp_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid || !req_ready));
endmodule

bind dm_victim_cache dm_victim_cache_chk #(.LA_W(LA_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit),
  .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
  .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack), .mem_wr_addr(mem_wr_addr),
  .mem_wr_data(mem_wr_data)
);

// File: tb/dm_victim_cache_test.sv
`timescale 1ns/1ps
module dm_victim_cache_test;
  localparam int ADDR_W = 12, WORD_W = 32, OFF_W = 1, IDX_W = 3;
  localparam int LA_W = ADDR_W - OFF_W, LINE_W = 2 * WORD_W, RD_LAT = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic req_ready, resp_valid, resp_hit;
  logic [WORD_W-1:0] resp_rdata;
  logic mem_rd_req, mem_rd_valid = 0, mem_wr_req, mem_wr_ack = 0;
  logic [LA_W-1:0] mem_rd_addr, mem_wr_addr;
  logic [LINE_W-1:0] mem_rd_data = '0, mem_wr_data;

  always #2.5 clk = ~clk;

  dm_victim_cache uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack));

  int checks = 0, failures = 0;
  int rd_count = 0, wb_count = 0;
  logic [LA_W-1:0]   last_wb_addr;
  logic [LINE_W-1:0] last_wb_data;
  logic [LINE_W-1:0] mem  [0:(1<<LA_W)-1];
  logic [WORD_W-1:0] refw [0:(1<<ADDR_W)-1];
  bit done = 0;

  function automatic logic [WORD_W-1:0] pat(input int a);
    return 32'hC0DE0000 | WORD_W'(a);
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int off);
    return {8'(tag), 3'(idx), 1'(off)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < (1 << LA_W); i++)
      mem[i] = {pat(2*i+1), pat(2*i)};
    forever begin
      @(negedge clk);
      if (mem_rd_valid) mem_rd_valid = 0;
      else if (mem_rd_req) begin
        repeat (RD_LAT - 1) @(negedge clk);
        mem_rd_data  = mem[mem_rd_addr];
        mem_rd_valid = 1;
        rd_count++;
      end
      if (mem_wr_ack) mem_wr_ack = 0;
      else if (mem_wr_req) begin
        mem[mem_wr_addr] = mem_wr_data;
        last_wb_addr = mem_wr_addr;
        last_wb_data = mem_wr_data;
        wb_count++;
        mem_wr_ack = 1;
      end
    end
  end

  task automatic reset_dut();
    rst_n = 0; req_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < (1 << LA_W); i++) begin
      refw[2*i]   = mem[i][WORD_W-1:0];
      refw[2*i+1] = mem[i][LINE_W-1:WORD_W];
    end
  endtask

  // kind: 0 = miss, 1 = main hit, 2 = victim hit
  task automatic access(input bit wr, input logic [ADDR_W-1:0] a,
                        input logic [WORD_W-1:0] wd, input int kind, input string req);
    int n;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 1;
    check(req_ready == (kind == 1), req, "ready after accept", req_ready, kind == 1);
    while (!resp_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    if (kind == 0) check(n > 2 && resp_valid, req, "miss latency", n, 3);
    else           check(n == kind, req, "hit latency", n, kind);
    check(resp_hit == (kind != 0), req, "resp_hit", resp_hit, kind != 0);
    if (!wr) check(resp_rdata == refw[a], req, "read data", resp_rdata, refw[a]);
    else     refw[a] = wd;
  endtask

  task automatic t_reset();
    reset_dut();
    check(req_ready == 1, "R1", "req_ready", req_ready, 1);
    check(resp_valid == 0, "R1", "resp_valid", resp_valid, 0);
    check(!mem_rd_req && !mem_wr_req, "R1", "mem requests", {mem_rd_req, mem_wr_req}, 0);
  endtask

  task automatic t_main();
    int r0;
    access(0, mk(1,2,0), 0, 0, "R4");
    access(0, mk(1,2,1), 0, 1, "R2");
    r0 = rd_count;
    access(1, mk(1,2,1), 32'hDEAD0001, 1, "R7");
    access(0, mk(1,2,1), 0, 1, "R7");
    check(rd_count == r0 && wb_count == 0, "R7", "write hit traffic", rd_count - r0 + wb_count, 0);
  endtask

  task automatic t_victim();
    access(0, mk(2,2,0), 0, 0, "R4");
    access(0, mk(1,2,1), 0, 2, "R3");
    access(0, mk(1,2,0), 0, 1, "R3");
    access(0, mk(2,2,0), 0, 2, "R3");
    access(1, mk(1,2,0), 32'hBEEF0002, 2, "R7");
    access(0, mk(1,2,0), 0, 1, "R8");
    access(0, mk(1,2,1), 0, 1, "R8");
    check(wb_count == 0, "R8", "no write-back while cached", wb_count, 0);
  endtask

  task automatic t_after_reset();
    t_reset();
    access(0, mk(2,2,0), 0, 0, "R1");
  endtask

  task automatic t_fifo();
    int w0, r0;
    logic [LINE_W-1:0] exp_line;
    reset_dut();
    w0 = wb_count;
    access(1, mk(1,5,0), 32'h0000F00D, 0, "R7");
    for (int t = 2; t <= 5; t++) access(0, mk(t,5,1), 0, 0, "R5");
    check(wb_count == w0, "R5", "no write-back while slots fill", wb_count - w0, 0);
    r0 = rd_count;
    access(0, mk(6,5,0), 0, 0, "R6");
    exp_line = {refw[mk(1,5,1)], refw[mk(1,5,0)]};
    check(wb_count == w0 + 1, "R6", "dirty oldest written back", wb_count - w0, 1);
    check(last_wb_addr == mk(1,5,0) >> 1, "R6", "write-back address", last_wb_addr, mk(1,5,0) >> 1);
    check(last_wb_data == exp_line, "R8", "write-back data", last_wb_data, exp_line);
    check(rd_count == r0 + 1, "R4", "one fill per miss", rd_count - r0, 1);
    access(0, mk(1,5,0), 0, 0, "R6");
    check(wb_count == w0 + 1, "R6", "clean occupant dropped", wb_count - w0, 1);
    access(0, mk(2,5,0), 0, 0, "R5");
    access(0, mk(4,5,1), 0, 2, "R5");
    access(0, mk(5,5,1), 0, 2, "R5");
  endtask

  task automatic t_write_miss();
    int r0;
    r0 = rd_count;
    access(1, mk(9,7,1), 32'h12345678, 0, "R7");
    check(rd_count == r0 + 1, "R7", "write miss fills", rd_count - r0, 1);
    access(0, mk(9,7,1), 0, 1, "R7");
    access(0, mk(9,7,0), 0, 1, "R7");
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          failures++;
          checks++;
          $display("FAIL watchdog expired");
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none
    t_reset();
    t_main();
    t_victim();
    t_after_reset();
    t_fifo();
    t_write_miss();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule